// File: doc/BRIEF.md
# Receive Character Queue with Fill Triggers

This block is the receive half of a buffered asynchronous serial channel. Characters that have already been assembled by a deserialiser arrive one per cycle on a valid/data pair. They are stored in a 16-entry first-in first-out queue and removed by reads of a data address on a small register port.

Two independent fill thresholds watch the queue. The first is a status trigger picked from the table {1, 4, 8, 14}. It drives two status flags: a "trigger reached" flag and a "some data, below trigger" flag. The second is a flow-control threshold picked from the table {15, 1, 4, 6, 8, 10, 12, 14}. It drives a `canAccept` output that tells the upstream source whether more characters are wanted. A character that arrives while the queue is full is lost, and this is recorded in a line status register. Reading that register returns its value and clears it.

Register map on `regAddr`: 0 is control (read/write), 1 is status (read-only), 2 is line status (read clears, write loads), and 3 is receive data (a read pops, a write is ignored). Reads are combinational from the current state. Their side effects take place at the clock edge that ends the read cycle.

Top module: `rxq_trig_top`

## Requirements
- R1: Characters accepted on `rxValid`/`rxData` are returned in arrival order by reads of address 3. Each such read removes the oldest character, and the queue holds up to 16 characters.
- R2: A character that arrives while 16 are held, with no pop in the same cycle, is discarded and sets bit 0 of the line status register (address 2).
- R3: Control bits [8:7] choose the status trigger level: value 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14 characters.
- R4: After every push or pop, status bit 1 equals (fill ≥ trigger level) and status bit 0 equals (0 < fill < trigger level). A control write alone leaves both flags unchanged.
- R5: `canAccept` is high exactly while the fill is below the flow threshold chosen by control bits [11:9]: 0 gives 15, 1 gives 1, and any other value n gives 2·n.
- R6: A read of address 2 returns the line status and clears it to zero. A write loads the written value. An overrun in the same cycle as a clearing read stays recorded.
- R7: The status register (address 1) reads 0x0060 after reset. Bits 6:5 always read one and bits 15:7 and 4:2 always read zero.
- R8: A read of address 3 while the queue is empty returns the most recently popped character (zero after reset) and changes nothing.
- R9: A push and a pop in the same cycle leave the fill unchanged, even when the queue is full, and record no overrun.
- R10: After reset the control and line status registers read zero, the queue is empty and `canAccept` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received character is presented this cycle |
| rxData | input | 8 | Received character |
| regAddr | input | 2 | Register select |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects at the clock edge) |
| regWrData | input | 16 | Register write value |
| regRdData | output | 16 | Register read value, combinational |
| canAccept | output | 1 | Flow control: fill below the selected threshold |

## Verification
On every cycle, the embedded properties check the following: the fill never exceeds the depth, a pop never hits an empty queue, a drop always sets the overrun bit, a clearing read empties the line status, the two flags are never both set and never move without a push or pop, and a full queue never reports `canAccept`. Only the bench's scenarios can show arrival order, the exact flag and `canAccept` values for each table entry, and the data returned by a pop of an empty queue. For this reason the bench sweeps every trigger and flow setting through a full fill-to-overrun-to-drain cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Register addresses on the register port
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_LINE = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // Control field positions (decoded by the threshold logic)
  localparam int TRIG_LSB = 7;
  localparam int FLOW_LSB = 9;

  // Constant bits of the status word
  localparam logic [15:0] STAT_BASE = 16'h0060;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

  // Status trigger table: 1, 4, 8, 14
  function automatic int trigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // Flow-control table: 15, 1, then twice the selector
  function automatic int flowLevel(input logic [2:0] sel);
    if (sel == 3'd0) return 15;
    if (sel == 3'd1) return 1;
    return 2 * int'(sel);
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [LEN_W-1:0]  length,
  output logic [DATA_W-1:0] headData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rdIdx, wrIdx;
  logic [LEN_W-1:0]  len;
  logic [DATA_W-1:0] lastData;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(DEPTH - 1)) return '0;
    return idx + IDX_W'(1);
  endfunction

  // Storage array, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdIdx    <= '0;
      wrIdx    <= '0;
      len      <= '0;
      lastData <= '0;
    end else begin
      if (strobe.push) wrIdx <= bump(wrIdx);
      if (strobe.pop) begin
        rdIdx    <= bump(rdIdx);
        lastData <= mem[rdIdx];
      end
      case ({strobe.push, strobe.pop})
        2'b10:   len <= len + LEN_W'(1);
        2'b01:   len <= len - LEN_W'(1);
        default: len <= len;
      endcase
    end
  end

  assign length   = len;
  assign headData = (len == '0) ? lastData : mem[rdIdx];

  // R1: fill level bounded by depth
  p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_W'(DEPTH));

  // R8: a pop is only issued on a non-empty queue
  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pop |-> len != '0);

  // R2: a lone push never lands on a full queue
  p_push_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.push && !strobe.pop) |-> len != LEN_W'(DEPTH));

  // R9: simultaneous push and pop keep the fill
  p_pushpop_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.push && strobe.pop) |=> $stable(len));

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxValid,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [LEN_W-1:0]  length,
  input  logic [DATA_W-1:0] headData,
  output fifoStrobe_t       strobe,
  output logic [REG_W-1:0]  regRdData,
  output logic              canAccept
);

  logic [REG_W-1:0] ctrlReg, lineReg, lineNext;
  logic             trigFlag, readyFlag;
  logic             popReq, doPop, doPush, drop;
  logic             lineRd, lineWr;
  int               nextLen, trigLvl, flowLvl;

  assign trigLvl = trigLevel(ctrlReg[TRIG_LSB +: 2]);
  assign flowLvl = flowLevel(ctrlReg[FLOW_LSB +: 3]);

  // Strobe generation
  assign popReq = regRdEn && (regAddr == ADDR_DATA);
  assign doPop  = popReq && (length != '0);
  assign doPush = rxValid && ((length != LEN_W'(DEPTH)) || doPop);
  assign drop   = rxValid && !doPush;
  assign strobe = '{push: doPush, pop: doPop};

  assign nextLen = int'(length) + (doPush ? 1 : 0) - (doPop ? 1 : 0);

  assign lineRd = regRdEn && (regAddr == ADDR_LINE);
  assign lineWr = regWrEn && (regAddr == ADDR_LINE);

  always_comb begin
    lineNext = lineReg;
    if (lineWr)      lineNext = regWrData;
    else if (lineRd) lineNext = '0;
    if (drop)        lineNext[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlReg   <= '0;
      lineReg   <= '0;
      trigFlag  <= 1'b0;
      readyFlag <= 1'b0;
    end else begin
      if (regWrEn && (regAddr == ADDR_CTRL)) ctrlReg <= regWrData;
      lineReg <= lineNext;
      if (doPush || doPop) begin
        trigFlag  <= (nextLen >= trigLvl);
        readyFlag <= (nextLen < trigLvl) && (nextLen > 0);
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlReg;
      ADDR_STAT: regRdData = REG_W'(STAT_BASE) | REG_W'({trigFlag, readyFlag});
      ADDR_LINE: regRdData = lineReg;
      default:   regRdData = REG_W'(headData);
    endcase
  end

  assign canAccept = int'(length) < flowLvl;

  // R2: a dropped character leaves the overrun bit set
  p_overrun_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> lineReg[0]);

  // R6: a clearing read without write or overrun empties line status
  p_line_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lineRd && !lineWr && !drop) |=> lineReg == '0);

  // R4: the two flags are mutually exclusive
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trigFlag && readyFlag));

  // R4: flags move only on a push or pop
  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.push || strobe.pop) |=> ($stable(trigFlag) && $stable(readyFlag)));

  // R5: a full queue never asks for more
  p_accept_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (length == LEN_W'(DEPTH)) |-> !canAccept);

endmodule

// File: rtl/rxq_trig_top.sv
module rxq_trig_top
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              canAccept
);

  localparam int LEN_W = $clog2(DEPTH + 1);

  fifoStrobe_t       strobe;
  logic [LEN_W-1:0]  length;
  logic [DATA_W-1:0] headData;

  rxq_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) datapath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .wrData   (rxData),
    .length   (length),
    .headData (headData)
  );

  rxq_control #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) control_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxValid   (rxValid),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .length    (length),
    .headData  (headData),
    .strobe    (strobe),
    .regRdData (regRdData),
    .canAccept (canAccept)
  );

endmodule

// File: tb/rxq_trig_top_tb_top.sv
module rxq_trig_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        canAccept;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model
  int q[$];
  int lastPop = 0;
  int lsrM = 0;
  int ctrlM = 0;
  bit trigM = 0;
  bit readyM = 0;

  always #5 clk = ~clk;

  rxq_trig_top dut_i (
    .clk(clk), .rst_n(rst_n), .rxValid(rxValid), .rxData(rxData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .canAccept(canAccept)
  );

  function automatic int trigOf(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
  endfunction

  function automatic int flowOf(int sel);
    return (sel == 0) ? 15 : (sel == 1) ? 1 : 2 * sel;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One bus cycle: optional push, read and write; checks the read value
  task automatic cyc(input bit v, input int d, input bit rd, input bit wr,
                     input int addr, input int wd, input string tag);
    int expRd, sz;
    bit popOk, pushOk, drop;
    sz = q.size();
    case (addr)
      0: expRd = ctrlM;
      1: expRd = 'h60 | (int'(trigM) << 1) | int'(readyM);
      2: expRd = lsrM;
      default: expRd = (sz > 0) ? q[0] : lastPop;
    endcase
    @(negedge clk);
    rxValid = v; rxData = 8'(d); regRdEn = rd; regWrEn = wr;
    regAddr = 2'(addr); regWrData = 16'(wd);
    #1;
    if (rd) check(tag, int'(regRdData), expRd);
    @(posedge clk);
    #1;
    rxValid = 0; regRdEn = 0; regWrEn = 0;
    popOk  = rd && addr == 3 && sz > 0;
    pushOk = v && (sz < 16 || popOk);
    drop   = v && !pushOk;
    if (popOk) lastPop = q.pop_front();
    if (pushOk) q.push_back(d & 255);
    if (pushOk || popOk) begin
      trigM  = q.size() >= trigOf((ctrlM >> 7) & 3);
      readyM = !trigM && q.size() > 0;
    end
    if (wr && addr == 2) lsrM = wd & 'hffff;
    else if (rd && addr == 2) lsrM = 0;
    if (drop) lsrM = lsrM | 1;
    if (wr && addr == 0) ctrlM = wd & 'hffff;
  endtask

  task automatic chkAccept(input string tag);
    @(negedge clk);
    check(tag, int'(canAccept), int'(q.size() < flowOf((ctrlM >> 9) & 7)));
  endtask

  task automatic push(input int d);
    cyc(1, d, 0, 0, 0, 0, "push");
  endtask

  task automatic rdReg(input int addr, input string tag);
    cyc(0, 0, 1, 0, addr, 0, tag);
  endtask

  task automatic wrReg(input int addr, input int wd);
    cyc(0, 0, 0, 1, addr, wd, "write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 / R7 / R8: reset state
    rdReg(0, "R10 ctrl reset");
    rdReg(1, "R7 status reset 0x0060");
    rdReg(2, "R10 line status reset");
    rdReg(3, "R8 empty pop after reset");
    chkAccept("R10 canAccept after reset");

    // Sweep every trigger and flow selection: fill, overrun, drain
    for (int ts = 0; ts < 4; ts++) begin
      for (int fs = 0; fs < 8; fs++) begin
        wrReg(0, (fs << 9) | (ts << 7));
        rdReg(0, "R3 ctrl readback");
        rdReg(1, "R4 flags unchanged by ctrl write");
        for (int k = 1; k <= 17; k++) begin
          push((ts * 40 + fs * 17 + k) & 255);
          rdReg(1, "R3 R4 status after push");
          chkAccept("R5 canAccept after push");
        end
        rdReg(2, "R2 overrun recorded");
        rdReg(2, "R6 line status cleared by read");
        for (int k = 1; k <= 17; k++) begin
          rdReg(3, "R1 pop order / R8 empty pop");
          rdReg(1, "R4 status after pop");
          chkAccept("R5 canAccept after pop");
        end
      end
    end

    // R9: push and pop together on a full queue
    wrReg(0, 0);
    for (int k = 0; k < 16; k++) push(k + 100);
    for (int k = 0; k < 8; k++) cyc(1, 200 + k, 1, 0, 3, 0, "R9 pop during push");
    rdReg(2, "R9 no overrun on push+pop");
    rdReg(1, "R9 status still full");
    chkAccept("R9 canAccept full");
    for (int k = 0; k < 17; k++) rdReg(3, "R9 drain order");
    rdReg(3, "R8 repeated empty pop");

    // R6: write loads, read returns and clears, overrun beats clear
    wrReg(2, 'hA5A4);
    rdReg(2, "R6 write loads");
    rdReg(2, "R6 read clears");
    for (int k = 0; k < 16; k++) push(k);
    cyc(1, 55, 1, 0, 2, 0, "R6 clearing read with overrun");
    rdReg(2, "R6 overrun survives clear");
    for (int k = 0; k < 16; k++) rdReg(3, "R1 drain");

    // R4: control write alone does not move flags
    wrReg(0, 2 << 7);
    for (int k = 0; k < 5; k++) push(k + 7);
    rdReg(1, "R4 below trigger 8");
    wrReg(0, 1 << 7);
    rdReg(1, "R4 ctrl write keeps flags");
    push(99);
    rdReg(1, "R4 push re-evaluates at trigger 4");
    cyc(0, 0, 0, 1, 3, 'h1234, "R1 data write ignored");
    rdReg(1, "R1 status after ignored write");
    for (int k = 0; k < 6; k++) rdReg(3, "R1 final drain");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule